// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block turns a three-wire stereo audio stream into parallel 24-bit samples. The inputs are a bit clock, a word clock that tells the two channels apart, and a serial data line. A 3-bit format code picks the framing. The framings are LSB-justified at 16, 20 or 24 bits, MSB-justified at 24 bits, and I2S. Samples are two's complement and arrive MSB first.

The whole block runs on one system clock. The bit clock, the word clock and the data line are sampled through two-flop synchronizers, and bit-clock rising edges are found by edge detection. When a right-channel word completes, both channel words are presented together and a single-cycle strobe marks them. A separate flag marks the reserved test code. Downstream zero detection uses that flag to ignore its own result.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is held and right after it is released, `word_valid` is 0 and both channel outputs are 0.
- R2: With format 3'b010 (24-bit MSB-justified), the 24 bits sampled starting at the first bit-clock rise after a word-clock change form the word. A high word clock marks the left channel.
- R3: With format 3'b011 (I2S), the bit at the first rise after a word-clock change is skipped and the next 24 bits form the word. A low word clock marks the left channel.
- R4: With format 3'b000, the last 16 bits before a word-clock change form the sample. It is sign-extended to 24 bits, and earlier bits in the half-frame have no effect.
- R5: With format 3'b001, the last 20 bits before a word-clock change form the sample, sign-extended to 24 bits.
- R6: With format 3'b100, the last 24 bits before a word-clock change form the sample.
- R7: Each stereo frame produces exactly one `word_valid` pulse, one system clock wide. It follows the end of the right-channel half, and the outputs hold between pulses.
- R8: `test_mode` is 1 exactly when the format is 3'b101. Codes 3'b101 to 3'b111 decode data as 24-bit LSB-justified.
- R9: 16-bit data with eight trailing zero bits, sent in the 24-bit MSB-justified format, arrives as that value shifted left by 8.
- R10: A frame already in progress when capture starts is dropped. The first pulse after reset carries the first frame whose left half was seen in full.
- R11: In the MSB-justified and I2S formats, bits after the 24th data bit of a half-frame have no effect.
- R12: Decoding is correct at the minimum bit-clock counts: 32 per frame for format 3'b000 and 40 per frame for format 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, data captured on its rising edge |
| wclk | input | 1 | Word clock selecting the channel |
| sdin | input | 1 | Serial audio data, MSB first |
| fmt | input | 3 | Framing select code |
| left_word | output | 24 | Left-channel sample |
| right_word | output | 24 | Right-channel sample |
| word_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |
| test_mode | output | 1 | Reserved test code is selected |

## Verification
Every framing is driven with words whose sign bit and LSB are both set, or whose patterns differ between channels. A swapped channel, a bit-order error or a one-bit misalignment therefore shows up as a wrong value. The LSB-justified cases pad the half-frame with ones ahead of the sample, and the MSB-justified and I2S cases pad after it. Padding that leaks into the word is caught, and wrong sign extension is caught too. The 16-bit and 20-bit cases run at their minimum bit-clock counts, where there is no padding at all. A reset followed by two frames separates correct alignment from a design that emits the partial first frame.

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          wclk,
  input  logic          sdin,
  input  logic [2:0]    fmt,
  output logic [SW-1:0] left_word,
  output logic [SW-1:0] right_word,
  output logic          word_valid,
  output logic          test_mode
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [2:0]    bc_q;
  logic [1:0]    ws_q, sd_q;
  logic          started, armed, have_left, ws_last;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sh, left_hold;

  logic          rise, ws, sd, i2s, msbj, boundary, take, ended_left;
  logic [CW-1:0] skip, cnt_eff;
  logic [SW-1:0] sh_base, sh_next, word;

  assign rise      = bc_q[1] & ~bc_q[2];
  assign ws        = ws_q[1];
  assign sd        = sd_q[1];
  assign i2s       = (fmt == 3'b011);
  assign msbj      = (fmt == 3'b010) | i2s;
  assign skip      = i2s ? CW'(1) : CW'(0);
  assign test_mode = (fmt == 3'b101);

  assign boundary   = rise & started & (ws != ws_last);
  assign cnt_eff    = boundary ? '0 : cnt;
  assign take       = !msbj || (cnt_eff >= skip && cnt_eff < skip + CW'(SW));
  assign sh_base    = boundary ? '0 : sh;
  assign sh_next    = take ? {sh_base[SW-2:0], sd} : sh_base;
  assign ended_left = (ws_last == ~i2s);

  always_comb begin
    case (fmt)
      3'b000:  word = {{(SW-16){sh[15]}}, sh[15:0]};
      3'b001:  word = {{(SW-20){sh[19]}}, sh[19:0]};
      default: word = sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_q <= '0;
      ws_q <= '0;
      sd_q <= '0;
    end else begin
      bc_q <= {bc_q[1:0], bclk};
      ws_q <= {ws_q[0], wclk};
      sd_q <= {sd_q[0], sdin};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started    <= 1'b0;
      armed      <= 1'b0;
      have_left  <= 1'b0;
      ws_last    <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      left_hold  <= '0;
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (rise) begin
        started <= 1'b1;
        ws_last <= ws;
        sh      <= sh_next;
        cnt     <= (cnt_eff == CMAX) ? cnt_eff : cnt_eff + CW'(1);
        if (boundary) begin
          armed <= 1'b1;
          if (armed) begin
            if (ended_left) begin
              left_hold <= word;
              have_left <= 1'b1;
            end else if (have_left) begin
              left_word  <= left_hold;
              right_word <= word;
              word_valid <= 1'b1;
              have_left  <= 1'b0;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    fmt,
  input logic [SW-1:0] left_word,
  input logic [SW-1:0] right_word,
  input logic          word_valid
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !word_valid); // R1

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(left_word) && $stable(right_word))); // R7

  AST_SIGN16: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(fmt) == 3'b000) |->
      ($countones(right_word[SW-1:15]) == 0 || $countones(right_word[SW-1:15]) == SW-15)); // R4

  AST_SIGN20: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(fmt) == 3'b001) |->
      ($countones(left_word[SW-1:19]) == 0 || $countones(left_word[SW-1:19]) == SW-19)); // R5

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(fmt),
  .left_word(left_word), .right_word(right_word), .word_valid(word_valid)
);

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;
  logic clk = 0, rst_n = 0, bclk = 0, wclk = 0, sdin = 0;
  logic [2:0] fmt = 3'b010;
  logic [23:0] left_word, right_word;
  logic word_valid, test_mode;

  aud_serial_rx u_aud_serial_rx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdin(sdin), .fmt(fmt),
    .left_word(left_word), .right_word(right_word), .word_valid(word_valid),
    .test_mode(test_mode)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, vcount = 0, dbl = 0;
  logic [23:0] cap_l = 0, cap_r = 0;
  logic prev_v = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (word_valid) begin
      vcount++;
      cap_l = left_word;
      cap_r = right_word;
      if (prev_v) dbl++;
    end
    prev_v = word_valid;
  end

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] sx(logic [23:0] w, int n);
    if (n == 16) return {{8{w[15]}}, w[15:0]};
    if (n == 20) return {{4{w[19]}}, w[19:0]};
    return w;
  endfunction

  task automatic drive_bit(logic lvl, logic b);
    @(negedge clk);
    bclk = 0; wclk = lvl; sdin = b;
    repeat (4) @(negedge clk);
    bclk = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(int bph, logic lvl, logic [23:0] w, logic fill);
    int n;
    n = (fmt == 3'b000) ? 16 : (fmt == 3'b001) ? 20 : 24;
    for (int i = 0; i < bph; i++) begin
      logic b;
      b = fill;
      if (fmt == 3'b010) begin
        if (i < 24) b = w[23-i];
      end else if (fmt == 3'b011) begin
        if (i >= 1 && i <= 24) b = w[24-i];
      end else if (i >= bph - n) begin
        b = w[n-1-(i-(bph-n))];
      end
      drive_bit(lvl, b);
    end
  endtask

  task automatic send_frame(int bph, logic [23:0] l, logic [23:0] r, logic fill);
    logic lv;
    lv = (fmt == 3'b011) ? 1'b0 : 1'b1;
    send_half(bph, lv, l, fill);
    send_half(bph, ~lv, r, fill);
  endtask

  task automatic run_case(string req, logic [2:0] f, int bph, logic [23:0] l, logic [23:0] r,
                          logic fill, logic [23:0] el, logic [23:0] er);
    int b0;
    fmt = f;
    send_frame(bph, 24'h13579b, 24'h2468ac, fill);
    send_frame(bph, l, r, fill);
    b0 = vcount;
    send_frame(bph, 24'h0, 24'h0, 1'b0);
    chk({req, " pulse count"}, 48'(vcount - b0), 48'd1);
    chk({req, " stereo pair"}, {cap_l, cap_r}, {el, er});
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", 48'(word_valid), 48'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 words after reset", {left_word, right_word}, 48'd0);
    chk("R1 valid after reset", 48'(word_valid), 48'd0);
    chk("R8 flag off for 010", 48'(test_mode), 48'd0);
  endtask

  task automatic t_align;
    int b0;
    b0 = vcount;
    send_frame(64, 24'h111111, 24'h222222, 1'b0);
    send_frame(64, 24'hA5C3E1, 24'h5A3C1E, 1'b0);
    send_frame(64, 24'h0, 24'h0, 1'b0);
    chk("R10 single pulse", 48'(vcount - b0), 48'd1);
    chk("R10 second frame", {cap_l, cap_r}, {24'hA5C3E1, 24'h5A3C1E});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog act=timeout exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_align();
    run_case("R2 msb 64", 3'b010, 64, 24'h8F1234, 24'h00ABC1, 1'b0, 24'h8F1234, 24'h00ABC1);
    run_case("R2 msb 48", 3'b010, 24, 24'hC0FFEE, 24'h7E0001, 1'b0, 24'hC0FFEE, 24'h7E0001);
    run_case("R9 msb 16-bit", 3'b010, 32, 24'hABCD00, 24'h123400, 1'b0, 24'hABCD00, 24'h123400);
    run_case("R11 msb tail", 3'b010, 32, 24'h5A5A5A, 24'hA00005, 1'b1, 24'h5A5A5A, 24'hA00005);
    run_case("R3 i2s", 3'b011, 32, 24'hC00001, 24'h7FFFFF, 1'b1, 24'hC00001, 24'h7FFFFF);
    run_case("R11 i2s tail", 3'b011, 32, 24'h800000, 24'h000001, 1'b0, 24'h800000, 24'h000001);
    run_case("R4 lsb16 64", 3'b000, 32, 24'h558001, 24'hAA7FFE, 1'b1,
             sx(24'h558001, 16), sx(24'hAA7FFE, 16));
    run_case("R12 lsb16 32", 3'b000, 16, 24'h00F00F, 24'h000FF0, 1'b0,
             sx(24'h00F00F, 16), sx(24'h000FF0, 16));
    run_case("R5 lsb20 64", 3'b001, 32, 24'h3C0001, 24'hC7FFFF, 1'b1,
             sx(24'h3C0001, 20), sx(24'hC7FFFF, 20));
    run_case("R12 lsb20 40", 3'b001, 20, 24'h080000, 24'h07FFFF, 1'b0,
             sx(24'h080000, 20), sx(24'h07FFFF, 20));
    run_case("R6 lsb24", 3'b100, 32, 24'h800000, 24'h000001, 1'b1, 24'h800000, 24'h000001);
    run_case("R8 test code", 3'b101, 32, 24'h9ABCDE, 24'h012345, 1'b1, 24'h9ABCDE, 24'h012345);
    chk("R8 flag on for 101", 48'(test_mode), 48'd1);
    fmt = 3'b100;
    @(negedge clk);
    chk("R8 flag off for 100", 48'(test_mode), 48'd0);
    chk("R7 pulse width", 48'(dbl), 48'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule